// File: doc/BRIEF.md
# DDR2 Command Spacing Checker

This block is a passive monitor for a DDR2 command bus. Every clock it takes one decoded command (activate, read, read with auto-precharge, write, write with auto-precharge, precharge or no-operation) together with the bank address. It keeps its own timers per bank and for the whole bus, and it flags any command that comes too soon after an earlier one. It does not drive the bus and does not model data, strobes, refresh or power states.

All nanosecond limits are parameters. At elaboration each one is turned into whole clocks by rounding up against a clock-period parameter. The write-data end point comes from the read latency, because write latency is read latency minus one, plus half the burst length. The auto-precharge recovery is the write-recovery setting in clocks plus the rounded-up precharge time. A violation produces a one-cycle report carrying a rule code, the bank and the offending command. A sticky flag stays set until reset, because a DRAM that has seen illegal spacing must be re-initialised anyway.

Top module: `ddr2_cmd_spacing_mon`

## Requirements
- R1: Each limit in picoseconds becomes ceil(limit_ps / TCK_PS) clocks at elaboration. The activate-to-activate limit uses 10000 ps when PAGE_2KB is 1 and 7500 ps when it is 0. With TCK_PS 3750 this gives 3 clocks and 2 clocks.
- R2: An activate (cmd 1) to a bank other than the one in the previous activate, issued fewer than the activate-spacing clocks after it, is reported with rule code 1. A repeat activate to the same bank is not checked by this rule.
- R3: A precharge (cmd 6) issued fewer than ceil(tRTP/tCK) clocks after a read or read with auto-precharge (cmd 2 or 3) to the same bank is reported with rule code 2.
- R4: A precharge issued fewer than (RL-1) + BL/2 + ceil(tWR/tCK) clocks after a write or write with auto-precharge (cmd 4 or 5) to the same bank is reported with rule code 3. With the defaults this limit is 10 clocks.
- R5: A read or read with auto-precharge to any bank, issued fewer than (RL-1) + BL/2 + ceil(tWTR/tCK) clocks after any write of either kind, is reported with rule code 4. With the defaults this limit is 8 clocks.
- R6: An activate issued fewer than (RL-1) + BL/2 + WR_CLK + ceil(tRP/tCK) clocks after a write with auto-precharge to the same bank is reported with rule code 5. With the defaults this limit is 6 + 8 = 14 clocks.
- R7: A violating command at cycle t drives err_valid_o high for exactly cycle t+1. In that cycle err_rule_o, err_bank_o and err_cmd_o hold the rule code, the command's bank and the command. When one command breaks several rules, the largest code is reported. In cycles with no report these three outputs are 0.
- R8: err_sticky_o rises together with the first report and stays high until reset, whatever commands follow.
- R9: Synchronous active-high reset clears all outputs and all timers, so no command after reset is judged against commands issued before it.
- R10: A command that meets every spacing, including a no-operation (cmd 0), produces no report.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_i | input | 3 | Decoded command: 0 nop, 1 activate, 2 read, 3 read+AP, 4 write, 5 write+AP, 6 precharge |
| bank_i | input | BA_W | Bank address of the command |
| err_sticky_o | output | 1 | Set on the first violation, held until reset |
| err_valid_o | output | 1 | One-cycle violation report |
| err_rule_o | output | 3 | Rule code: 1 act-act, 2 read-pre, 3 write recovery, 4 write-read, 5 auto-precharge to act |
| err_bank_o | output | BA_W | Bank of the offending command |
| err_cmd_o | output | 3 | Offending command code |

## Verification
The timers are never visible directly. A wrong count shows up as a report one cycle too early or too late at the exact boundary gap, which shows at err_valid_o in the cycle after the command. For this reason every rule is driven at its limit minus one clock and at its limit. A timer that is indexed by the wrong bank, or that is not cleared by reset, shows as a spurious report on a compliant command one cycle after that command. A wrong priority shows as the wrong err_rule_o on a precharge that breaks both precharge rules.

// File: rtl/ddr2_spc_pkg.sv
`timescale 1ns/1ps
package ddr2_spc_pkg;
  localparam int CMD_W  = 3;
  localparam int RULE_W = 3;
  localparam int NRULE  = 5;

  localparam logic [CMD_W-1:0] CMD_NOP = 3'd0;
  localparam logic [CMD_W-1:0] CMD_ACT = 3'd1;
  localparam logic [CMD_W-1:0] CMD_RD  = 3'd2;
  localparam logic [CMD_W-1:0] CMD_RDA = 3'd3;
  localparam logic [CMD_W-1:0] CMD_WR  = 3'd4;
  localparam logic [CMD_W-1:0] CMD_WRA = 3'd5;
  localparam logic [CMD_W-1:0] CMD_PRE = 3'd6;

  // rule codes; a larger code wins when several fire together
  localparam logic [RULE_W-1:0] RULE_NONE = 3'd0;
  localparam logic [RULE_W-1:0] RULE_RRD  = 3'd1;
  localparam logic [RULE_W-1:0] RULE_RTP  = 3'd2;
  localparam logic [RULE_W-1:0] RULE_WREC = 3'd3;
  localparam logic [RULE_W-1:0] RULE_WTR  = 3'd4;
  localparam logic [RULE_W-1:0] RULE_DAL  = 3'd5;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ddr2_spc_hold_cnt.sv
`timescale 1ns/1ps
// Busy while fewer than LIM clocks have passed since the last load.
module ddr2_spc_hold_cnt #(
  parameter int CW  = 4,
  parameter int LIM = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic busy
);
  localparam logic [CW-1:0] LOADV = CW'(LIM - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= LOADV;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/ddr2_spc_bank_timer.sv
`timescale 1ns/1ps
// Per-bank spacing state: read-to-precharge, write recovery, auto-precharge.
module ddr2_spc_bank_timer #(
  parameter int CW       = 4,
  parameter int RTP_LIM  = 2,
  parameter int WREC_LIM = 10,
  parameter int DAL_LIM  = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_hit,
  input  logic wr_hit,
  input  logic wra_hit,
  output logic rtp_busy,
  output logic wrec_busy,
  output logic dal_busy
);
  ddr2_spc_hold_cnt #(.CW(CW), .LIM(RTP_LIM)) u_rtp (
    .clk(clk), .rst(rst), .load(rd_hit), .busy(rtp_busy)
  );

  ddr2_spc_hold_cnt #(.CW(CW), .LIM(WREC_LIM)) u_wrec (
    .clk(clk), .rst(rst), .load(wr_hit), .busy(wrec_busy)
  );

  ddr2_spc_hold_cnt #(.CW(CW), .LIM(DAL_LIM)) u_dal (
    .clk(clk), .rst(rst), .load(wra_hit), .busy(dal_busy)
  );
endmodule

// File: rtl/ddr2_spc_bus_timer.sv
`timescale 1ns/1ps
// Bus-wide spacing state: activate-to-activate and write-to-read.
module ddr2_spc_bus_timer #(
  parameter int CW      = 4,
  parameter int BA_W    = 3,
  parameter int RRD_LIM = 2,
  parameter int WTR_LIM = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            act_seen,
  input  logic            wr_seen,
  input  logic [BA_W-1:0] bank,
  output logic            rrd_busy,
  output logic [BA_W-1:0] last_act_bank,
  output logic            wtr_busy
);
  ddr2_spc_hold_cnt #(.CW(CW), .LIM(RRD_LIM)) u_rrd (
    .clk(clk), .rst(rst), .load(act_seen), .busy(rrd_busy)
  );

  ddr2_spc_hold_cnt #(.CW(CW), .LIM(WTR_LIM)) u_wtr (
    .clk(clk), .rst(rst), .load(wr_seen), .busy(wtr_busy)
  );

  always_ff @(posedge clk) begin
    if (rst)           last_act_bank <= '0;
    else if (act_seen) last_act_bank <= bank;
  end
endmodule

// File: rtl/ddr2_spc_reporter.sv
`timescale 1ns/1ps
// Picks the highest rule that fired and registers the report.
module ddr2_spc_reporter
  import ddr2_spc_pkg::*;
#(
  parameter int BA_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NRULE-1:0]  hit,
  input  logic [BA_W-1:0]   bank,
  input  logic [CMD_W-1:0]  cmd,
  output logic              sticky,
  output logic              valid,
  output logic [RULE_W-1:0] rule,
  output logic [BA_W-1:0]   rep_bank,
  output logic [CMD_W-1:0]  rep_cmd
);
  logic [RULE_W-1:0] code;
  logic              any;

  always_comb begin
    code = RULE_NONE;
    for (int k = 0; k < NRULE; k++) begin
      if (hit[k]) code = RULE_W'(k + 1);
    end
  end

  assign any = |hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      sticky   <= 1'b0;
      valid    <= 1'b0;
      rule     <= RULE_NONE;
      rep_bank <= '0;
      rep_cmd  <= CMD_NOP;
    end else begin
      sticky   <= sticky | any;
      valid    <= any;
      rule     <= code;
      rep_bank <= any ? bank : '0;
      rep_cmd  <= any ? cmd : CMD_NOP;
    end
  end
endmodule

// File: rtl/ddr2_cmd_spacing_mon.sv
`timescale 1ns/1ps
module ddr2_cmd_spacing_mon
  import ddr2_spc_pkg::*;
#(
  parameter int NUM_BANKS  = 8,
  parameter int TCK_PS     = 3750,
  parameter int RL         = 5,
  parameter int BL         = 4,
  parameter int PAGE_2KB   = 0,
  parameter int WR_CLK     = 4,
  parameter int TRRD_1K_PS = 7500,
  parameter int TRRD_2K_PS = 10000,
  parameter int TRTP_PS    = 7500,
  parameter int TWR_PS     = 15000,
  parameter int TWTR_PS    = 7500,
  parameter int TRP_PS     = 15000,
  localparam int BA_W      = $clog2(NUM_BANKS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2:0]      cmd_i,
  input  logic [BA_W-1:0] bank_i,
  output logic            err_sticky_o,
  output logic            err_valid_o,
  output logic [2:0]      err_rule_o,
  output logic [BA_W-1:0] err_bank_o,
  output logic [2:0]      err_cmd_o
);
  // elaboration-time conversion to clocks
  localparam int WL        = RL - 1;
  localparam int WDATA_END = WL + BL / 2;
  localparam int RRD_PS    = (PAGE_2KB != 0) ? TRRD_2K_PS : TRRD_1K_PS;
  localparam int RRD_LIM   = max2(1, ceil_div(RRD_PS, TCK_PS));
  localparam int RTP_LIM   = max2(1, ceil_div(TRTP_PS, TCK_PS));
  localparam int WREC_LIM  = WDATA_END + ceil_div(TWR_PS, TCK_PS);
  localparam int WTR_LIM   = WDATA_END + ceil_div(TWTR_PS, TCK_PS);
  localparam int DAL_LIM   = WDATA_END + WR_CLK + ceil_div(TRP_PS, TCK_PS);
  localparam int MAX_LIM   = max2(max2(max2(RRD_LIM, RTP_LIM), max2(WREC_LIM, WTR_LIM)), DAL_LIM);
  localparam int CW        = $clog2(MAX_LIM + 1);

  logic is_act, is_rd, is_wr, is_wra, is_pre;

  assign is_act = (cmd_i == CMD_ACT);
  assign is_rd  = (cmd_i == CMD_RD) || (cmd_i == CMD_RDA);
  assign is_wr  = (cmd_i == CMD_WR) || (cmd_i == CMD_WRA);
  assign is_wra = (cmd_i == CMD_WRA);
  assign is_pre = (cmd_i == CMD_PRE);

  logic [NUM_BANKS-1:0] rtp_busy, wrec_busy, dal_busy;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = (bank_i == BA_W'(b));

    ddr2_spc_bank_timer #(
      .CW(CW), .RTP_LIM(RTP_LIM), .WREC_LIM(WREC_LIM), .DAL_LIM(DAL_LIM)
    ) u_bt (
      .clk(clk), .rst(rst),
      .rd_hit(sel && is_rd), .wr_hit(sel && is_wr), .wra_hit(sel && is_wra),
      .rtp_busy(rtp_busy[b]), .wrec_busy(wrec_busy[b]), .dal_busy(dal_busy[b])
    );
  end

  logic            rrd_busy, wtr_busy;
  logic [BA_W-1:0] last_act_bank;

  ddr2_spc_bus_timer #(
    .CW(CW), .BA_W(BA_W), .RRD_LIM(RRD_LIM), .WTR_LIM(WTR_LIM)
  ) u_bus (
    .clk(clk), .rst(rst), .act_seen(is_act), .wr_seen(is_wr), .bank(bank_i),
    .rrd_busy(rrd_busy), .last_act_bank(last_act_bank), .wtr_busy(wtr_busy)
  );

  // bit k carries rule code k+1
  logic [NRULE-1:0] hit;

  assign hit[0] = is_act && rrd_busy && (bank_i != last_act_bank);
  assign hit[1] = is_pre && rtp_busy[bank_i];
  assign hit[2] = is_pre && wrec_busy[bank_i];
  assign hit[3] = is_rd  && wtr_busy;
  assign hit[4] = is_act && dal_busy[bank_i];

  ddr2_spc_reporter #(.BA_W(BA_W)) u_rep (
    .clk(clk), .rst(rst), .hit(hit), .bank(bank_i), .cmd(cmd_i),
    .sticky(err_sticky_o), .valid(err_valid_o), .rule(err_rule_o),
    .rep_bank(err_bank_o), .rep_cmd(err_cmd_o)
  );
endmodule

// File: rtl/ddr2_cmd_spacing_mon_chk.sv
`timescale 1ns/1ps
module ddr2_cmd_spacing_mon_chk
  import ddr2_spc_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [2:0] cmd_i,
  input logic       err_sticky_o,
  input logic       err_valid_o,
  input logic [2:0] err_rule_o,
  input logic [2:0] err_cmd_o
);
  // R8: a report always comes with the sticky flag
  p_report_sets_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    err_valid_o |-> err_sticky_o);

  // R8: the sticky flag never drops without reset
  p_sticky_holds_r8: assert property (@(posedge clk) disable iff (rst)
    err_sticky_o |=> err_sticky_o);

  // R7: a report carries a defined rule code and the command just seen
  p_code_defined_r7: assert property (@(posedge clk) disable iff (rst)
    err_valid_o |-> (err_rule_o >= RULE_RRD && err_rule_o <= RULE_DAL));

  p_cmd_echo_r7: assert property (@(posedge clk) disable iff (rst)
    err_valid_o |-> (err_cmd_o == $past(cmd_i)));

  // R7: outputs idle when there is no report
  p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !err_valid_o |-> (err_rule_o == RULE_NONE && err_cmd_o == CMD_NOP));

  // R10: a no-operation never causes a report
  p_nop_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == CMD_NOP) |=> !err_valid_o);

  // R5: write-to-read code only follows a read
  p_wtr_on_read_r5: assert property (@(posedge clk) disable iff (rst)
    !(cmd_i == CMD_RD || cmd_i == CMD_RDA) |=> !(err_valid_o && err_rule_o == RULE_WTR));

  // R3/R4: precharge codes only follow a precharge
  p_pre_codes_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_i != CMD_PRE) |=> !(err_valid_o && (err_rule_o == RULE_RTP || err_rule_o == RULE_WREC)));

  // R2/R6: activate codes only follow an activate
  p_act_codes_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_i != CMD_ACT) |=> !(err_valid_o && (err_rule_o == RULE_RRD || err_rule_o == RULE_DAL)));
endmodule

bind ddr2_cmd_spacing_mon ddr2_cmd_spacing_mon_chk u_chk (
  .clk(clk), .rst(rst), .cmd_i(cmd_i), .err_sticky_o(err_sticky_o),
  .err_valid_o(err_valid_o), .err_rule_o(err_rule_o), .err_cmd_o(err_cmd_o)
);

// File: tb/ddr2_cmd_spacing_mon_bench.sv
`timescale 1ns/1ps
module ddr2_cmd_spacing_mon_bench;
  localparam real HALF = 2.5; // 200 MHz

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cmd = 3'd0, cmd2 = 3'd0;
  logic [2:0] bank = 3'd0, bank2 = 3'd0;

  logic       stk, vld, stk2, vld2;
  logic [2:0] rule, rbank, rcmd, rule2, rbank2, rcmd2;

  int total = 0;
  int bad   = 0;

  always #(HALF) clk = ~clk;

  ddr2_cmd_spacing_mon u_ddr2_cmd_spacing_mon (
    .clk(clk), .rst(rst), .cmd_i(cmd), .bank_i(bank),
    .err_sticky_o(stk), .err_valid_o(vld), .err_rule_o(rule),
    .err_bank_o(rbank), .err_cmd_o(rcmd)
  );

  ddr2_cmd_spacing_mon #(.PAGE_2KB(1)) u_ddr2_cmd_spacing_mon_2k (
    .clk(clk), .rst(rst), .cmd_i(cmd2), .bank_i(bank2),
    .err_sticky_o(stk2), .err_valid_o(vld2), .err_rule_o(rule2),
    .err_bank_o(rbank2), .err_cmd_o(rcmd2)
  );

  // commands: 0 nop 1 act 2 rd 3 rda 4 wr 5 wra 6 pre
  // row = {cmd, bank, expected valid, expected rule}
  localparam int NV = 37;
  localparam logic [9:0] VEC [NV] = '{
    {3'd1,3'd0,1'b0,3'd0}, // 0  act b0
    {3'd1,3'd1,1'b1,3'd1}, // 1  act b1 gap1 -> R2
    {3'd0,3'd0,1'b0,3'd0}, // 2
    {3'd1,3'd2,1'b0,3'd0}, // 3  act b2 gap2 ok
    {3'd2,3'd2,1'b0,3'd0}, // 4  rd b2
    {3'd6,3'd2,1'b1,3'd2}, // 5  pre b2 gap1 -> R3
    {3'd2,3'd3,1'b0,3'd0}, // 6  rd b3
    {3'd0,3'd0,1'b0,3'd0}, // 7
    {3'd6,3'd3,1'b0,3'd0}, // 8  pre b3 gap2 ok
    {3'd4,3'd4,1'b0,3'd0}, // 9  wr b4
    {3'd0,3'd0,1'b0,3'd0}, // 10
    {3'd0,3'd0,1'b0,3'd0}, // 11
    {3'd0,3'd0,1'b0,3'd0}, // 12
    {3'd0,3'd0,1'b0,3'd0}, // 13
    {3'd0,3'd0,1'b0,3'd0}, // 14
    {3'd0,3'd0,1'b0,3'd0}, // 15
    {3'd2,3'd5,1'b1,3'd4}, // 16 rd b5 gap7 -> R5
    {3'd2,3'd5,1'b0,3'd0}, // 17 rd b5 gap8 ok
    {3'd6,3'd4,1'b1,3'd3}, // 18 pre b4 gap9 -> R4
    {3'd6,3'd4,1'b0,3'd0}, // 19 pre b4 gap10 ok
    {3'd5,3'd6,1'b0,3'd0}, // 20 wra b6
    {3'd0,3'd0,1'b0,3'd0}, // 21
    {3'd0,3'd0,1'b0,3'd0}, // 22
    {3'd0,3'd0,1'b0,3'd0}, // 23
    {3'd0,3'd0,1'b0,3'd0}, // 24
    {3'd0,3'd0,1'b0,3'd0}, // 25
    {3'd0,3'd0,1'b0,3'd0}, // 26
    {3'd3,3'd0,1'b1,3'd4}, // 27 rda b0 gap7 after wra -> R5
    {3'd2,3'd0,1'b0,3'd0}, // 28 rd b0 gap8 ok
    {3'd0,3'd0,1'b0,3'd0}, // 29
    {3'd0,3'd0,1'b0,3'd0}, // 30
    {3'd0,3'd0,1'b0,3'd0}, // 31
    {3'd0,3'd0,1'b0,3'd0}, // 32
    {3'd1,3'd6,1'b1,3'd5}, // 33 act b6 gap13 -> R6
    {3'd1,3'd6,1'b0,3'd0}, // 34 act b6 gap14 ok, same bank no R2
    {3'd1,3'd7,1'b1,3'd1}, // 35 act b7 gap1 -> R2
    {3'd0,3'd0,1'b0,3'd0}  // 36
  };

  function automatic string tag_of(input logic [2:0] r);
    case (r)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic issue(input logic [2:0] c, input logic [2:0] b);
    @(negedge clk);
    cmd  = c;
    bank = b;
  endtask

  task automatic issue2(input logic [2:0] c, input logic [2:0] b);
    @(negedge clk);
    cmd2  = c;
    bank2 = b;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cmd = 3'd0; cmd2 = 3'd0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(HALF * 2 * 100000);
    total++;
    bad++;
    $display("FAIL watchdog R9 got=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic exp_stk;
    logic [9:0] row;
    // R9: reset state
    repeat (3) @(negedge clk);
    chk("R9 reset outputs", {stk, vld, rule, rbank, rcmd}, 32'd0);
    chk("R9 reset outputs 2k", {stk2, vld2, rule2, rbank2, rcmd2}, 32'd0);
    rst = 1'b0;

    // table walk; result of row i is visible while row i+1 is driven
    exp_stk = 1'b0;
    for (int i = 0; i <= NV; i++) begin
      if (i < NV) issue(VEC[i][9:7], VEC[i][6:4]);
      else        issue(3'd0, 3'd0);
      if (i > 0) begin
        row = VEC[i-1];
        if (row[3]) exp_stk = 1'b1;
        chk($sformatf("%s row%0d", tag_of(row[2:0]), i - 1),
            {stk, vld, rule, rbank, rcmd},
            {exp_stk, row[3], row[2:0],
             row[3] ? row[6:4] : 3'd0, row[3] ? row[9:7] : 3'd0});
      end
    end

    // R7: precharge breaking both precharge rules reports the larger code
    do_reset();
    issue(3'd4, 3'd0);
    repeat (7) issue(3'd0, 3'd0);
    issue(3'd2, 3'd0);            // read at gap 8: allowed
    issue(3'd6, 3'd0);            // pre: gap1 after rd, gap9 after wr
    chk("R5 read at limit", {stk, vld}, 32'd0);
    issue(3'd0, 3'd0);
    chk("R7 priority", {stk, vld, rule, rbank, rcmd}, {1'b1, 1'b1, 3'd3, 3'd0, 3'd6});

    // R8: sticky flag survives a long quiet stretch
    repeat (20) issue(3'd0, 3'd0);
    chk("R8 sticky held", {stk, vld, rule}, {1'b1, 1'b0, 3'd0});

    // R9: reset clears pending timers
    do_reset();
    issue(3'd4, 3'd1);
    @(negedge clk);
    rst = 1'b1; cmd = 3'd0;
    @(negedge clk);
    rst = 1'b0; cmd = 3'd2; bank = 3'd1;
    @(negedge clk);
    cmd = 3'd0;
    chk("R9 timers cleared", {stk, vld, rule}, 32'd0);

    // R1: 2KB page gives a 3-clock activate spacing at 3750 ps
    issue2(3'd1, 3'd0);
    issue2(3'd0, 3'd0);
    issue2(3'd1, 3'd1);           // gap 2
    issue2(3'd0, 3'd0);
    chk("R1 2k gap2", {stk2, vld2, rule2, rbank2, rcmd2}, {1'b1, 1'b1, 3'd1, 3'd1, 3'd1});
    issue2(3'd0, 3'd0);
    issue2(3'd1, 3'd2);           // gap 3
    issue2(3'd0, 3'd0);
    chk("R1 2k gap3", {vld2, rule2}, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule